// File: doc/BRIEF.md
# Multi-Profile SPI Master Sequencer

This block is an SPI bus master that moves one frame per accepted command. Before each frame it takes one of six stored transfer profiles, chosen by a selector carried with the command. The profile fixes how the frame runs: its length, its bit order, the clock idle level and which clock edge launches and which samples, the serial clock rate, and three chip-select timing intervals. These are the select-to-first-edge lead, the last-edge-to-deselect lag and the idle gap before the next frame. A double-rate option halves the clock divide ratio. This allows odd divide ratios, and the two clock halves then become unequal.

The profiles sit in a small 32-bit register file on a simple write-strobe / combinational-read port. A frame starts when `cmd_valid` is high while `cmd_ready` is high. The received word comes back with a one-cycle `rx_valid` pulse near the end of the frame. The block has one chip-select, the serial clock and the data lines, and nothing else.

Top module: `spi_profile_master`

## Requirements
- R1: After reset every profile register reads 0x7800_0000. `cs_n` is 1, `sck` is 0, `cmd_ready` is 1 and `rx_valid` is 0.
- R2: Profile i (0..5) is read and written at byte address 0x0C + 4*i. Any other address reads 0, and writes to it change no profile.
- R3: Profile layout (bit 31 is the top bit): [31] double-rate, [30:27] size code S, [26] idle clock level, [25] phase, [24] LSB-first, [23:22] lead prescaler, [21:20] lag prescaler, [19:18] gap prescaler, [17:16] baud prescaler, [15:12] lead scaler, [11:8] lag scaler, [7:4] gap scaler, [3:0] baud scaler.
- R4: A frame carries S+1 bits, or 4 bits when S is below 3. There are exactly two clock edges per bit.
- R5: With LSB-first at 0 the payload leaves from bit N-1 down to bit 0. With it at 1 the payload leaves from bit 0 up. Received bits are placed in `rx_data` by the same mapping, and the bits above N read 0.
- R6: Outside the clocking part of a frame, `sck` rests at the frame's idle level. The leading edge moves it away from that level.
- R7: Prescaler codes 0..3 mean 2, 3, 5, 7. Baud scaler codes 0..3 mean 2, 4, 6, 8, and code c of 4 or more means 2^c. The SCK period P is the baud prescaler times the baud scaler, halved when double-rate is 1. With double-rate at 0 both halves last P/2 cycles.
- R8: With double-rate at 1 and P odd, the half after the leading edge lasts floor(P/2) cycles when phase is 0 and ceil(P/2) cycles when phase is 1. The other half takes the rest of P.
- R9: `cs_n` falls one cycle after acceptance. The first edge comes lead cycles later, `cs_n` rises lag cycles after the last edge, and `cmd_ready` returns gap cycles after that. Each interval is its prescaler times 2^(scaler code + 1).
- R10: The command selector picks the profile for that frame. Selector values 6 and 7 use profile 0.
- R11: A profile is captured when its frame is accepted. A write landing during a frame does not affect it, but it governs the next frame that selects that profile.
- R12: `rx_valid` pulses for one cycle, in the cycle after the final edge, while `cs_n` is still low. `cmd_ready` is high only while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_valid | input | 1 | Frame command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle |
| cmd_prof | input | SEL_W | Profile selector for the frame |
| cmd_data | input | 16 | Transmit payload, right-aligned |
| rx_valid | output | 1 | Received word valid pulse |
| rx_data | output | 16 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
A wrong phase counter or a wrong captured profile shows up at the pins within one frame. It appears as an edge interval that is one or more cycles off, a wrong edge count, or an idle clock level that is wrong between frames. A wrong bit-index mapping shows up within the same frame, either as a swapped or shifted bit on `mosi` at a sample edge or in `rx_data` at the `rx_valid` pulse. A register-file fault is seen on the next read, or in the timing of the next frame that uses the damaged profile.

// File: rtl/spm_pkg.sv
package spm_pkg;

   localparam int SIZE_W = 4;
   localparam int DATA_W = 1 << SIZE_W;
   localparam int MIN_BITS = 4;
   localparam logic [31:0] PROF_RST = 32'h7800_0000;

   typedef struct packed {
      logic             dbl;
      logic [SIZE_W-1:0] size;
      logic             cpol;
      logic             cpha;
      logic             lsb_first;
      logic [1:0]       lead_pre;
      logic [1:0]       lag_pre;
      logic [1:0]       gap_pre;
      logic [1:0]       baud_pre;
      logic [3:0]       lead_scl;
      logic [3:0]       lag_scl;
      logic [3:0]       gap_scl;
      logic [3:0]       baud_scl;
   } prof_t;

   typedef enum logic [2:0] {
      S_IDLE, S_LEAD, S_SHIFT, S_LAG, S_GAP
   } seq_st_t;

   function automatic logic [31:0] pre_val(input logic [1:0] c);
      case (c)
         2'd0:    return 32'd2;
         2'd1:    return 32'd3;
         2'd2:    return 32'd5;
         default: return 32'd7;
      endcase
   endfunction

   function automatic logic [31:0] baud_val(input logic [3:0] c);
      return (c < 4'd4) ? (32'(c) * 32'd2 + 32'd2) : (32'd1 << c);
   endfunction

   function automatic logic [31:0] dly_val(input logic [3:0] c);
      return 32'd2 << c;
   endfunction

   function automatic logic [SIZE_W:0] frame_bits(input logic [SIZE_W-1:0] s);
      return (s < SIZE_W'(MIN_BITS - 1)) ? (SIZE_W+1)'(MIN_BITS) : ({1'b0, s} + 1'b1);
   endfunction

   function automatic logic [SIZE_W-1:0] bit_map(input logic lsb, input logic [SIZE_W:0] nb,
                                                 input logic [SIZE_W-1:0] k);
      return lsb ? k : (SIZE_W'(nb - 1'b1) - k);
   endfunction

endpackage

// File: rtl/spm_profile_regs.sv
module spm_profile_regs
   import spm_pkg::*;
#(
   parameter int          NUM_PROF  = 6,
   parameter int          ADDR_W    = 8,
   parameter int          BASE_ADDR = 'h0C
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [31:0]            wdata,
   output logic [31:0]            rdata,
   output logic [NUM_PROF*32-1:0] prof_flat
);

   for (genvar i = 0; i < NUM_PROF; i++) begin : g_prof
      localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BASE_ADDR + 4 * i);
      logic [31:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       word_q <= PROF_RST;
         else if (wr_en && addr == SLOT)   word_q <= wdata;
      end

      assign prof_flat[i*32 +: 32] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_PROF; i++) begin
         if (addr == ADDR_W'(BASE_ADDR + 4 * i)) rdata = prof_flat[i*32 +: 32];
      end
   end

endmodule

// File: rtl/spm_timing.sv
module spm_timing
   import spm_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  prof_t             prof,
   output logic [CNT_W-1:0]  half_lead,
   output logic [CNT_W-1:0]  half_trail,
   output logic [CNT_W-1:0]  t_lead,
   output logic [CNT_W-1:0]  t_lag,
   output logic [CNT_W-1:0]  t_gap
);

   logic [CNT_W-1:0] period, lo, hi;

   always_comb begin
      period = CNT_W'(pre_val(prof.baud_pre) * baud_val(prof.baud_scl));
      if (prof.dbl) period = period >> 1;
      lo = period >> 1;
      hi = period - lo;
   end

   assign half_lead  = prof.cpha ? hi : lo;
   assign half_trail = prof.cpha ? lo : hi;
   assign t_lead = CNT_W'(pre_val(prof.lead_pre) * dly_val(prof.lead_scl));
   assign t_lag  = CNT_W'(pre_val(prof.lag_pre)  * dly_val(prof.lag_scl));
   assign t_gap  = CNT_W'(pre_val(prof.gap_pre)  * dly_val(prof.gap_scl));

endmodule

// File: rtl/spi_profile_master.sv
module spi_profile_master
   import spm_pkg::*;
#(
   parameter int   NUM_PROF  = 6,
   parameter int   ADDR_W    = 8,
   parameter int   BASE_ADDR = 'h0C,
   parameter int   CNT_W     = 20,
   localparam int  SEL_W     = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [SEL_W-1:0]  cmd_prof,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso
);

   localparam int HW = $clog2(2 * DATA_W);

   if (NUM_PROF < 1 || NUM_PROF > 8) begin : g_bad_prof
      $error("spi_profile_master: NUM_PROF must be 1..8");
   end
   if (CNT_W < 19) begin : g_bad_cnt
      $error("spi_profile_master: CNT_W too narrow for the longest interval");
   end
   if ((BASE_ADDR % 4) != 0) begin : g_bad_base
      $error("spi_profile_master: BASE_ADDR must be word aligned");
   end

   logic [NUM_PROF*32-1:0] prof_flat;
   prof_t                  sel_prof, cur;
   seq_st_t                st;
   logic [CNT_W-1:0]       cnt, lim, lim_m1;
   logic [CNT_W-1:0]       h_lead, h_trail, t_lead, t_lag, t_gap;
   logic [HW-1:0]          hcnt, last_h;
   logic [SIZE_W:0]        nb, sel_nb;
   logic [SIZE_W-1:0]      k;
   logic [DATA_W-1:0]      txd, rxd;
   logic                   mosi_q, cs_q, rxv_q, expire;

   spm_profile_regs #(
      .NUM_PROF (NUM_PROF),
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .prof_flat(prof_flat)
   );

   spm_timing #(.CNT_W(CNT_W)) u_timing (
      .prof      (cur),
      .half_lead (h_lead),
      .half_trail(h_trail),
      .t_lead    (t_lead),
      .t_lag     (t_lag),
      .t_gap     (t_gap)
   );

   always_comb begin
      if (32'(cmd_prof) < NUM_PROF) sel_prof = prof_t'(prof_flat[32'(cmd_prof)*32 +: 32]);
      else                          sel_prof = prof_t'(prof_flat[31:0]);
   end

   assign sel_nb = frame_bits(sel_prof.size);
   assign nb     = frame_bits(cur.size);
   assign last_h = HW'(2 * 32'(nb) - 2);
   assign k      = SIZE_W'((hcnt + 1'b1) >> 1);

   always_comb begin
      case (st)
         S_LEAD:  lim = t_lead;
         S_SHIFT: lim = hcnt[0] ? h_trail : h_lead;
         S_LAG:   lim = t_lag;
         default: lim = t_gap;
      endcase
   end
   assign lim_m1 = lim - CNT_W'(1);
   assign expire = (cnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cnt    <= '0;
         hcnt   <= '0;
         cur    <= prof_t'(PROF_RST);
         txd    <= '0;
         rxd    <= '0;
         mosi_q <= 1'b0;
         cs_q   <= 1'b1;
         rxv_q  <= 1'b0;
      end else begin
         rxv_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (cmd_valid) begin
                  cur    <= sel_prof;
                  txd    <= cmd_data;
                  rxd    <= '0;
                  cs_q   <= 1'b0;
                  cnt    <= '0;
                  hcnt   <= '0;
                  mosi_q <= sel_prof.cpha ? 1'b0 :
                            cmd_data[bit_map(sel_prof.lsb_first, sel_nb, '0)];
                  st     <= S_LEAD;
               end
            end
            S_LEAD: begin
               if (expire) begin
                  cnt  <= '0;
                  hcnt <= '0;
                  st   <= S_SHIFT;
                  if (cur.cpha) mosi_q <= txd[bit_map(cur.lsb_first, nb, '0)];
                  else          rxd[bit_map(cur.lsb_first, nb, '0)] <= miso;
               end else cnt <= cnt + 1'b1;
            end
            S_SHIFT: begin
               if (expire) begin
                  cnt <= '0;
                  if (!hcnt[0]) begin
                     if (cur.cpha)
                        rxd[bit_map(cur.lsb_first, nb, k)] <= miso;
                     else if (hcnt != last_h)
                        mosi_q <= txd[bit_map(cur.lsb_first, nb, k + 1'b1)];
                     if (hcnt == last_h) begin
                        st    <= S_LAG;
                        rxv_q <= 1'b1;
                     end else hcnt <= hcnt + 1'b1;
                  end else begin
                     if (cur.cpha) mosi_q <= txd[bit_map(cur.lsb_first, nb, k)];
                     else          rxd[bit_map(cur.lsb_first, nb, k)] <= miso;
                     hcnt <= hcnt + 1'b1;
                  end
               end else cnt <= cnt + 1'b1;
            end
            S_LAG: begin
               if (expire) begin
                  cnt    <= '0;
                  cs_q   <= 1'b1;
                  mosi_q <= 1'b0;
                  st     <= S_GAP;
               end else cnt <= cnt + 1'b1;
            end
            S_GAP: begin
               if (expire) begin
                  cnt <= '0;
                  st  <= S_IDLE;
               end else cnt <= cnt + 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st == S_IDLE);
   assign sck       = cur.cpol ^ ((st == S_SHIFT) && !hcnt[0]);
   assign mosi      = mosi_q;
   assign cs_n      = cs_q;
   assign rx_valid  = rxv_q;
   assign rx_data   = rxd;

endmodule

// File: rtl/spm_checker.sv
module spm_checker (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic cs_n,
   input logic sck,
   input logic rx_valid
);

   p_ready_deselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> cs_n);

   p_accept_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cs_n);

   p_rx_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_rx_inside_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !cs_n);

   p_sck_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> $stable(sck));

endmodule

bind spi_profile_master spm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cs_n     (cs_n),
   .sck      (sck),
   .rx_valid (rx_valid)
);

// File: tb/spi_profile_master_tb.sv
module spi_profile_master_tb;

   localparam int NP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_prof = '0;
   logic [15:0] cmd_data = '0;
   logic        rx_valid;
   logic [15:0] rx_data;
   logic        sck, mosi, cs_n;
   logic        miso = 1'b0;

   always #2.5 clk = ~clk;

   spi_profile_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_prof(cmd_prof), .cmd_data(cmd_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
      .cs_n(cs_n), .miso(miso)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] shadow [NP];

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R3 layout, built field by field
   function automatic logic [31:0] mk(input bit dbl, input int size, input bit cpol, input bit cpha,
                                      input bit lsb, input int lead_p, input int lag_p, input int gap_p,
                                      input int baud_p, input int lead_s, input int lag_s,
                                      input int gap_s, input int baud_s);
      return {dbl, 4'(size), cpol, cpha, lsb, 2'(lead_p), 2'(lag_p), 2'(gap_p), 2'(baud_p),
              4'(lead_s), 4'(lag_s), 4'(gap_s), 4'(baud_s)};
   endfunction

   function automatic int b_pre(input int c);
      int t [4] = '{2, 3, 5, 7};
      return t[c];
   endfunction

   function automatic int b_baud(input int c);
      return (c < 4) ? 2 * (c + 1) : (1 << c);
   endfunction

   function automatic int b_dly(input int p, input int s);
      return b_pre(p) * (1 << (s + 1));
   endfunction

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic run_frame(input int sel, input logic [15:0] tx, input logic [15:0] srx,
                            input string half_req, input bit mid_wr, input int mid_idx,
                            input logic [31:0] mid_val);
      int eff = (sel < NP) ? sel : 0;
      logic [31:0] v = shadow[eff];
      bit dbl = v[31], cpol = v[26], cpha = v[25], lsb = v[24];
      int size = int'(v[30:27]);
      int n = (size < 3) ? 4 : size + 1;
      int per = b_pre(int'(v[17:16])) * b_baud(int'(v[3:0]));
      int lo, hi, hl, ht, tlead, tlag, tgap;
      int cyc = 0, last_e = 0, e = 0, lead = -1, bad = 0, nrx = 0, rxc = -1, g = 0;
      logic [15:0] got = '0, rxv = '0, mask;
      logic last_sck;
      if (dbl) per = per / 2;
      lo = per / 2; hi = per - lo;
      hl = cpha ? hi : lo; ht = cpha ? lo : hi;
      tlead = b_dly(int'(v[23:22]), int'(v[15:12]));
      tlag  = b_dly(int'(v[21:20]), int'(v[11:8]));
      tgap  = b_dly(int'(v[19:18]), int'(v[7:4]));
      mask  = 16'((32'd1 << n) - 1);

      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_prof = 3'(sel); cmd_data = tx;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9", "cs_n after accept", cs_n, 0);
      chk("R12", "cmd_ready during frame", cmd_ready, 0);
      if (!cpha) miso = srx[lsb ? 0 : n - 1];
      if (mid_wr) begin
         reg_wr = 1'b1; reg_addr = 8'(12 + 4 * mid_idx); reg_wdata = mid_val;
      end
      last_sck = cpol;
      while (cs_n == 1'b0 && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) reg_wr = 1'b0;
         if (rx_valid) begin nrx++; rxc = cyc; rxv = rx_data; end
         if (sck !== last_sck) begin
            int iv = cyc - last_e;
            int kk = e / 2;
            if (e == 0) lead = iv;
            else if (iv != ((e % 2 == 1) ? hl : ht)) bad++;
            if (((!cpha && e % 2 == 0) || (cpha && e % 2 == 1)) && kk < n)
               got[lsb ? kk : n - 1 - kk] = mosi;
            if (!cpha && e % 2 == 1 && kk + 1 < n) miso = srx[lsb ? kk + 1 : n - 2 - kk];
            if (cpha && e % 2 == 0 && kk < n) miso = srx[lsb ? kk : n - 1 - kk];
            last_sck = sck; last_e = cyc; e++;
         end
      end
      chk("R9", "lead interval", lead, tlead);
      chk(half_req, "half intervals off", bad, 0);
      chk("R4", "edge count", e, 2 * n);
      chk("R5", "mosi word", got, tx & mask);
      chk("R5", "rx word", rxv, srx & mask);
      chk("R12", "rx_valid pulses", nrx, 1);
      chk("R12", "rx_valid cycle", rxc, last_e);
      chk("R9", "lag interval", cyc - last_e, tlag);
      chk("R6", "idle sck level", sck, cpol);
      while (!cmd_ready && g < 4000) begin @(negedge clk); g++; end
      chk("R9", "gap interval", g, tgap);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1", "cs_n", cs_n, 1);
      chk("R1", "sck", sck, 0);
      chk("R1", "cmd_ready", cmd_ready, 1);
      chk("R1", "rx_valid", rx_valid, 0);
      for (int i = 0; i < NP; i++) begin
         reg_read(8'(12 + 4 * i), d);
         chk("R1", "profile reset value", d, 32'h7800_0000);
      end
   endtask

   task automatic t_regs;
      logic [31:0] d;
      for (int i = 0; i < NP; i++) reg_write(8'(12 + 4 * i), 32'h1357_9BDF ^ (32'h1111_1111 * i));
      reg_write(8'h08, 32'hDEAD_BEEF);
      reg_write(8'h24, 32'hCAFE_F00D);
      for (int i = 0; i < NP; i++) begin
         reg_read(8'(12 + 4 * i), d);
         chk("R2", "profile readback", d, 32'h1357_9BDF ^ (32'h1111_1111 * i));
      end
      reg_read(8'h08, d);
      chk("R2", "unmapped read 0x08", d, 0);
      reg_read(8'h24, d);
      chk("R2", "unmapped read 0x24", d, 0);
   endtask

   task automatic t_load;
      shadow[0] = mk(0, 7, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0);
      shadow[1] = mk(0, 11, 1, 1, 1, 2, 0, 3, 1, 1, 1, 0, 1);
      shadow[2] = mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      shadow[3] = mk(1, 2, 0, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
      shadow[4] = mk(0, 9, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < NP - 1; i++) reg_write(8'(12 + 4 * i), shadow[i]);
      shadow[5] = 32'h7800_0000;
      reg_write(8'h20, shadow[5]);
   endtask

   task automatic t_msb_mode0;
      run_frame(0, 16'h00A5, 16'h003C, "R7", 0, 0, '0);
      run_frame(4, 16'h02D3, 16'h0165, "R7", 0, 0, '0);
   endtask

   task automatic t_lsb_mode1;
      run_frame(1, 16'h09B4, 16'h05E1, "R3", 0, 0, '0);
   endtask

   task automatic t_double_rate;
      run_frame(2, 16'h000B, 16'h0006, "R8", 0, 0, '0);
      run_frame(3, 16'h0004, 16'h0003, "R8", 0, 0, '0);
   endtask

   task automatic t_default_size;
      run_frame(5, 16'hBEEF, 16'h1C3A, "R7", 0, 0, '0);
   endtask

   task automatic t_selector;
      // R10: selector 7 is out of range and must behave as profile 0
      run_frame(7, 16'h0081, 16'h00F0, "R10", 0, 0, '0);
      run_frame(6, 16'h0042, 16'h0011, "R10", 0, 0, '0);
   endtask

   task automatic t_midframe_write;
      logic [31:0] nv = mk(0, 3, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
      // R11: frame uses the profile captured at acceptance
      run_frame(0, 16'h00C3, 16'h005A, "R11", 1, 0, nv);
      shadow[0] = nv;
      run_frame(0, 16'h0009, 16'h0006, "R11", 0, 0, '0);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_load;
      t_msb_mode0;
      t_lsb_mode1;
      t_double_rate;
      t_default_size;
      t_selector;
      t_midframe_write;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule